// File: doc/BRIEF.md
# Memory Extension Field Registers

This block holds the small registers that widen a 12-bit machine address into a 15-bit one. It keeps a 3-bit data field and a 3-bit instruction field. It also keeps a 3-bit instruction buffer that stages the next instruction field, a user buffer bit and a user flag bit. A 7-bit save-field register takes a snapshot of the user buffer, the instruction buffer and the data field, so that an interrupt handler can restore them later. A 3-bit extended-address register selects which field goes in front of the 12-bit bus address: data, instruction, buffer or zero.

Each register has its own operation-code input, and every register updates on the same rising clock edge. The sources of each register are the accumulator, the instruction register, the switch register and the other field registers. Bits are numbered here with bit 0 as the least significant bit. The sequencer that decides which operation to issue in each cycle lives outside this block.

Top module: `memext_fields`

## Requirements
- R1: While `rst_n` is low, all of the following are zero: `dfld`, `ifld`, `ibuf`, `uflag`, `savef`, `xfld`, and the internal user buffer.
- R2: `df_op` controls the data field: 1 clears it; 2 loads `acc[2:0]`; 3 loads `instr[5:3]`; 4 loads `savef[2:0]`; 5 loads `sw[2:0]`. Codes 0, 6 and 7 hold it.
- R3: `ib_op` controls the instruction buffer: 1 clears it; 2 loads `acc[5:3]`; 3 loads `instr[5:3]`; 4 loads `savef[5:3]`. Codes 0, 5, 6 and 7 hold it.
- R4: `if_op` controls the instruction field: 0 holds it; 1 clears it; 2 copies the instruction buffer; 3 loads `sw[5:3]`.
- R5: `ub_op` controls the user buffer: 1 clears it; 2 sets it; 3 loads `acc[6]`; 4 loads `savef[6]`. Codes 0, 5, 6 and 7 hold it. The user buffer is observed through R6 and R7.
- R6: `uf_op` controls the user flag: 0 holds it; 1 clears it; 2 sets it; 3 copies the user buffer.
- R7: When `sf_cap` is 1, `savef` loads the user buffer into bit 6, the instruction buffer into bits 5:3 and the data field into bits 2:0. When `sf_cap` is 0, `savef` holds.
- R8: `xma_op` controls the extended-address field `xfld`: 1 clears it (zero-field access); 2 takes the data field; 3 takes the instruction field; 4 takes the instruction buffer. Codes 0, 5, 6 and 7 hold it.
- R9: `xaddr` equals `{xfld, addr}` in the same cycle. `xfld` is bits 14:12.
- R10: All registers update on one edge from their values before that edge. A capture, copy or select issued together with a load of its source sees the old source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc | input | 12 | Accumulator value |
| instr | input | 12 | Instruction register value |
| sw | input | 12 | Switch register value |
| addr | input | 12 | 12-bit bus address |
| df_op | input | 3 | Data field operation |
| ib_op | input | 3 | Instruction buffer operation |
| if_op | input | 2 | Instruction field operation |
| ub_op | input | 3 | User buffer operation |
| uf_op | input | 2 | User flag operation |
| sf_cap | input | 1 | Save-field capture strobe |
| xma_op | input | 3 | Extended-address field operation |
| dfld | output | 3 | Data field |
| ifld | output | 3 | Instruction field |
| ibuf | output | 3 | Instruction buffer |
| uflag | output | 1 | User flag |
| savef | output | 7 | Save-field snapshot |
| xfld | output | 3 | Extended-address field |
| xaddr | output | 15 | 15-bit extended address |

## Verification
The hardest case to reach is the same-edge ordering. It happens when a save-field capture, an instruction-field copy or a field select lands in the same cycle as a new load of its source. Only a design that reads the pre-edge value gives the right result then. The user buffer has no port of its own, so it must be seen indirectly: either copied into the user flag or captured into the save field.

Directed sequences set up distinct old and new source values and then issue the load and the consumer together. A long random run with every operation code drawn independently covers the remaining combinations, including the codes that hold.

// File: rtl/memext_fields.sv
module memext_fields #(
  parameter int AW = 12,
  parameter int FW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   acc,
  input  logic [AW-1:0]   instr,
  input  logic [AW-1:0]   sw,
  input  logic [AW-1:0]   addr,
  input  logic [2:0]      df_op,
  input  logic [2:0]      ib_op,
  input  logic [1:0]      if_op,
  input  logic [2:0]      ub_op,
  input  logic [1:0]      uf_op,
  input  logic            sf_cap,
  input  logic [2:0]      xma_op,
  output logic [FW-1:0]   dfld,
  output logic [FW-1:0]   ifld,
  output logic [FW-1:0]   ibuf,
  output logic            uflag,
  output logic [2*FW:0]   savef,
  output logic [FW-1:0]   xfld,
  output logic [AW+FW-1:0] xaddr
);
  localparam int SW = 2*FW + 1;

  logic ubuf;

  wire [FW-1:0] acc_lo = acc[FW-1:0];
  wire [FW-1:0] acc_mid = acc[2*FW-1:FW];
  wire [FW-1:0] ins_mid = instr[2*FW-1:FW];
  wire [FW-1:0] sw_lo = sw[FW-1:0];
  wire [FW-1:0] sw_mid = sw[2*FW-1:FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dfld  <= '0;
      ifld  <= '0;
      ibuf  <= '0;
      ubuf  <= 1'b0;
      uflag <= 1'b0;
      savef <= '0;
      xfld  <= '0;
    end else begin
      case (df_op)
        3'd1: dfld <= '0;
        3'd2: dfld <= acc_lo;
        3'd3: dfld <= ins_mid;
        3'd4: dfld <= savef[FW-1:0];
        3'd5: dfld <= sw_lo;
        default: ;
      endcase

      case (ib_op)
        3'd1: ibuf <= '0;
        3'd2: ibuf <= acc_mid;
        3'd3: ibuf <= ins_mid;
        3'd4: ibuf <= savef[2*FW-1:FW];
        default: ;
      endcase

      case (if_op)
        2'd1: ifld <= '0;
        2'd2: ifld <= ibuf;
        2'd3: ifld <= sw_mid;
        default: ;
      endcase

      case (ub_op)
        3'd1: ubuf <= 1'b0;
        3'd2: ubuf <= 1'b1;
        3'd3: ubuf <= acc[2*FW];
        3'd4: ubuf <= savef[SW-1];
        default: ;
      endcase

      case (uf_op)
        2'd1: uflag <= 1'b0;
        2'd2: uflag <= 1'b1;
        2'd3: uflag <= ubuf;
        default: ;
      endcase

      if (sf_cap) savef <= {ubuf, ibuf, dfld};

      case (xma_op)
        3'd1: xfld <= '0;
        3'd2: xfld <= dfld;
        3'd3: xfld <= ifld;
        3'd4: xfld <= ibuf;
        default: ;
      endcase
    end
  end

  assign xaddr = {xfld, addr};
endmodule

module memext_fields_chk #(
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    df_op,
  input logic [1:0]    if_op,
  input logic [1:0]    uf_op,
  input logic          sf_cap,
  input logic [2:0]    xma_op,
  input logic [FW-1:0] dfld,
  input logic [FW-1:0] ifld,
  input logic [FW-1:0] ibuf,
  input logic          ubuf,
  input logic          uflag,
  input logic [2*FW:0] savef,
  input logic [FW-1:0] xfld
);
  // R7
  sf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_cap |=> savef == {$past(ubuf), $past(ibuf), $past(dfld)});
  // R7
  sf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_cap |=> $stable(savef));
  // R4
  if_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_op == 2'd2 |=> ifld == $past(ibuf));
  // R6
  uf_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_op == 2'd3 |=> uflag == $past(ubuf));
  // R2
  df_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (df_op == 3'd0 || df_op > 3'd5) |=> $stable(dfld));
  // R8
  xma_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xma_op == 3'd1 |=> xfld == '0);
  // R8
  xma_df_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xma_op == 3'd2 |=> xfld == $past(dfld));
endmodule

bind memext_fields memext_fields_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .df_op(df_op), .if_op(if_op), .uf_op(uf_op),
  .sf_cap(sf_cap), .xma_op(xma_op), .dfld(dfld), .ifld(ifld), .ibuf(ibuf),
  .ubuf(ubuf), .uflag(uflag), .savef(savef), .xfld(xfld)
);

// File: tb/memext_fields_test.sv
`timescale 1ns/1ps
module memext_fields_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] acc = '0, instr = '0, sw = '0, addr = '0;
  logic [2:0] df_op = '0, ib_op = '0, ub_op = '0, xma_op = '0;
  logic [1:0] if_op = '0, uf_op = '0;
  logic sf_cap = 1'b0;
  logic [2:0] dfld, ifld, ibuf, xfld;
  logic uflag;
  logic [6:0] savef;
  logic [14:0] xaddr;

  int checks = 0;
  int fails = 0;
  int m_df, m_if, m_ib, m_ub, m_uf, m_sf, m_x;

  always #2.5 clk = ~clk;

  memext_fields uut (
    .clk(clk), .rst_n(rst_n), .acc(acc), .instr(instr), .sw(sw), .addr(addr),
    .df_op(df_op), .ib_op(ib_op), .if_op(if_op), .ub_op(ub_op), .uf_op(uf_op),
    .sf_cap(sf_cap), .xma_op(xma_op), .dfld(dfld), .ifld(ifld), .ibuf(ibuf),
    .uflag(uflag), .savef(savef), .xfld(xfld), .xaddr(xaddr)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string note);
    check({"R2 dfld ", note}, dfld, m_df);
    check({"R3 ibuf ", note}, ibuf, m_ib);
    check({"R4 ifld ", note}, ifld, m_if);
    check({"R6 uflag ", note}, uflag, m_uf);
    check({"R7 savef ", note}, savef, m_sf);
    check({"R8 xfld ", note}, xfld, m_x);
    check({"R9 xaddr ", note}, xaddr, m_x * 4096 + int'(addr));
  endtask

  task automatic model_step();
    int n_df = m_df, n_if = m_if, n_ib = m_ib, n_ub = m_ub;
    int n_uf = m_uf, n_sf = m_sf, n_x = m_x;
    case (int'(df_op))
      1: n_df = 0;
      2: n_df = int'(acc) % 8;
      3: n_df = (int'(instr) / 8) % 8;
      4: n_df = m_sf % 8;
      5: n_df = int'(sw) % 8;
      default: ;
    endcase
    case (int'(ib_op))
      1: n_ib = 0;
      2: n_ib = (int'(acc) / 8) % 8;
      3: n_ib = (int'(instr) / 8) % 8;
      4: n_ib = (m_sf / 8) % 8;
      default: ;
    endcase
    case (int'(if_op))
      1: n_if = 0;
      2: n_if = m_ib;
      3: n_if = (int'(sw) / 8) % 8;
      default: ;
    endcase
    case (int'(ub_op))
      1: n_ub = 0;
      2: n_ub = 1;
      3: n_ub = (int'(acc) / 64) % 2;
      4: n_ub = m_sf / 64;
      default: ;
    endcase
    case (int'(uf_op))
      1: n_uf = 0;
      2: n_uf = 1;
      3: n_uf = m_ub;
      default: ;
    endcase
    if (sf_cap) n_sf = m_ub * 64 + m_ib * 8 + m_df;
    case (int'(xma_op))
      1: n_x = 0;
      2: n_x = m_df;
      3: n_x = m_if;
      4: n_x = m_ib;
      default: ;
    endcase
    m_df = n_df; m_if = n_if; m_ib = n_ib; m_ub = n_ub;
    m_uf = n_uf; m_sf = n_sf; m_x = n_x;
  endtask

  task automatic tick(string note);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(note);
  endtask

  task automatic idle();
    df_op = 0; ib_op = 0; if_op = 0; ub_op = 0; uf_op = 0; sf_cap = 0; xma_op = 0;
  endtask

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_df = 0; m_if = 0; m_ib = 0; m_ub = 0; m_uf = 0; m_sf = 0; m_x = 0;
    acc = 12'hFFF; instr = 12'hFFF; sw = 12'hFFF; addr = 12'h5A5;
    df_op = 5; ib_op = 2; if_op = 3; ub_op = 2; uf_op = 2; sf_cap = 1; xma_op = 4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1 reset");
    idle();
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R5 R6: distinct loads
    acc = 12'o0152; instr = 12'o0330; sw = 12'o0064;
    df_op = 2; ib_op = 2; ub_op = 3; tick("acc loads");
    idle(); uf_op = 3; tick("R5 ub via uf");
    df_op = 3; ib_op = 3; if_op = 3; tick("instr/sw loads");
    idle(); df_op = 5; if_op = 2; tick("sw df, if copy");

    // R10: capture together with new loads sees old values
    idle(); ub_op = 2; tick("ub set");
    acc = 12'o0777;
    sf_cap = 1; df_op = 2; ib_op = 2; ub_op = 1; if_op = 2; xma_op = 4; uf_op = 3;
    tick("R10 same-edge");
    idle(); xma_op = 2; tick("R8 xma df");
    idle(); xma_op = 3; tick("R8 xma if");
    idle(); df_op = 4; ib_op = 4; ub_op = 4; tick("R7 restore");
    idle(); uf_op = 3; sf_cap = 1; tick("R5 restored ub");
    idle(); xma_op = 1; addr = 12'hABC; tick("R8 zero field");

    // R11-like hold codes
    idle(); df_op = 7; ib_op = 6; ub_op = 5; xma_op = 6; tick("R2 R3 R8 hold codes");

    for (int i = 0; i < 3000; i++) begin
      acc = 12'($urandom); instr = 12'($urandom); sw = 12'($urandom);
      addr = 12'($urandom);
      df_op = 3'($urandom); ib_op = 3'($urandom); if_op = 2'($urandom);
      ub_op = 3'($urandom); uf_op = 2'($urandom);
      sf_cap = 1'($urandom); xma_op = 3'($urandom);
      tick("random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule